// File: doc/BRIEF.md
# Multi-master two-wire bus master

This block is a bit-level master for an open-drain two-wire serial bus with one clock line and one data line. The host asks for a transfer by naming a 7-bit target, a direction and a byte count. The controller waits until the bus is free and issues a START. It then sends the address byte and either sends data bytes taken from the host or receives bytes and returns them to the host. It ends with a STOP. The pads are driven only as open-drain pull-down enables. The sampled line levels come back through a two-flop synchronizer.

Several such masters may share one bus. Each master watches the data line while it shifts out address and write-data bits. A master that releases the line to send a 1 but sees it held low has lost to another master. The loser lets go of both lines on the next clock, raises a sticky loss flag, skips its STOP and returns to idle, so the winner's transfer goes on undisturbed. A new command from the host then waits for the bus to become free again before it starts.

Top module: `tw_master`

## Requirements
- R1: A START is issued only while the bus is free. The bus becomes free when a STOP is seen (data rising while the clock is high) or when both synchronized lines have been high for FREE_CYC consecutive cycles. It stops being free as soon as either line is seen low. After reset the bus is treated as busy until FREE_CYC high cycles have passed.
- R2: A transfer is a START, then the address byte, then the data bytes, then a STOP. The address byte is {addr[6:0], dir}, with dir = 1 for read and 0 for write. Every byte goes out most significant bit first and is followed by one acknowledge slot.
- R3: While a transfer runs, the data line changes only while the clock line is low. The only exceptions are the START (data falls while the clock is high) and the STOP (data rises while the clock is high).
- R4: On a write, each data byte is taken from wr_data in the cycle where wr_take is high, one pulse per byte. The acknowledge slot is then sampled, and a low level counts as ACK.
- R5: If the target does not acknowledge the address, nack_seen is set, no data byte is taken or sent, and a STOP follows.
- R6: If the target does not acknowledge a written data byte, the transfer ends after that byte with a STOP, nack_seen is set, and no further byte is taken.
- R7: On a read of N bytes, N bytes are presented on rd_data, each with a one-cycle rd_valid pulse. The master drives ACK (low) after every byte except the last one, and leaves the data line released (NACK) after the last byte before the STOP.
- R8: If the master releases the data line for a 1 bit of the address or of write data and samples it low, it releases both lines on the next clock, sets arb_lost and clears busy. It issues no STOP, and the winning master's bytes reach the target intact.
- R9: arb_lost and nack_seen stay set until the next accepted command clears them. A command given after a loss does not drive the bus until the bus is free again.
- R10: The clock line stays high for 2*(div+1) cycles in every bit, and a full bit lasts 4*(div+1) cycles.
- R11: After reset both line enables are low and busy, arb_lost and nack_seen are low. A completed STOP produces a one-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| cmd_start | input | 1 | Start a transfer; accepted when idle |
| cmd_addr | input | 7 | Target address |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_count | input | CNT_W | Number of data bytes |
| wr_data | input | 8 | Write byte, captured while wr_take is high |
| wr_take | output | 1 | Write byte captured this cycle |
| rd_data | output | 8 | Last byte received |
| rd_valid | output | 1 | One-cycle pulse, rd_data is new |
| busy | output | 1 | Command accepted and not finished |
| done | output | 1 | One-cycle pulse after a STOP |
| nack_seen | output | 1 | Sticky: address or write byte was not acknowledged |
| arb_lost | output | 1 | Sticky: arbitration lost |
| scl_i | input | 1 | Clock line level from the pad |
| sda_i | input | 1 | Data line level from the pad |
| scl_oe | output | 1 | Pull the clock line low |
| sda_oe | output | 1 | Pull the data line low |

## Verification
The bench builds two instances with FREE_CYC = 32, MAX_BYTES = 8 and DIV_W = 8. They share a wired-AND bus with a behavioural target that acknowledges one address, refuses one chosen data value and serves read bytes. A FREE_CYC of 32 is long enough that no high pause inside a transfer (at most 2*(div+1) cycles) makes the bus look free. It is still short enough that the wait after reset and the retry after a loss can be measured within a few hundred cycles. The div input runs at 3 and then 5, so the high-time check covers two quarter lengths. Because both instances share the same divider setting and the same synchronized bus view, they can start in the same cycle and run bit for bit in step. This brings a real arbitration loss within reach: once on the last address bit, and once on the first address bit followed by a retry.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_START,
        ST_BIT,
        ST_STOP
    } tw_state_e;

    localparam logic [3:0] ACK_SLOT = 4'd8;
    localparam logic [1:0] PH_LAST  = 2'd3;

    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
    } tw_head_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } tw_drive_t;

    function automatic logic [7:0] head_byte(input tw_head_t h);
        return {h.addr, h.rd};
    endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tw_tick.sv
module tw_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R10: ticks are spaced by div+1 cycles
    a_r10_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/tw_busmon.sv
module tw_busmon #(
    parameter int FREE_CYC = 64,
    parameter int FC_W     = $clog2(FREE_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic bus_free
);
    logic            sda_prev;
    logic [FC_W-1:0] hi_cnt;
    logic            stop_seen;

    assign stop_seen = scl_s && sda_s && !sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_prev <= 1'b1;
            hi_cnt   <= '0;
            bus_free <= 1'b0;
        end else begin
            sda_prev <= sda_s;
            if (!scl_s || !sda_s) begin
                hi_cnt   <= '0;
                bus_free <= 1'b0;
            end else if (stop_seen) begin
                bus_free <= 1'b1;
            end else if (hi_cnt == FC_W'(FREE_CYC - 1)) begin
                bus_free <= 1'b1;
            end else begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    // R1: a low line withdraws the free indication
    a_r1_low_line_busy: assert property (@(posedge clk) disable iff (rst)
        (!scl_s || !sda_s) |=> !bus_free);
endmodule

// File: rtl/tw_master.sv
module tw_master
    import tw_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int FREE_CYC  = 64,
    parameter int MAX_BYTES = 16,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             cmd_start,
    input  logic [6:0]       cmd_addr,
    input  logic             cmd_read,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             nack_seen,
    output logic             arb_lost,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic [1:0] line_s;
    logic       scl_s, sda_s, tick, bus_free;

    tw_sync #(.W(2)) u_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    tw_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(div), .tick(tick)
    );

    tw_busmon #(.FREE_CYC(FREE_CYC)) u_busmon (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .bus_free(bus_free)
    );

    tw_state_e        st, st_n;
    logic [1:0]       ph, ph_n;
    logic [3:0]       bitn, bitn_n;
    logic [7:0]       sh, sh_n, rdd_n;
    logic             rx, rx_n, is_addr, is_addr_n;
    logic             nack_n, lost_n, done_n, rdv_n;
    logic [CNT_W-1:0] left, left_n, left_dec;
    tw_head_t         head, head_n;
    tw_drive_t        drv_n;

    assign busy = (st != ST_IDLE);

    always_comb begin
        st_n = st;  ph_n = ph;  bitn_n = bitn;  sh_n = sh;
        rx_n = rx;  is_addr_n = is_addr;  left_n = left;  head_n = head;
        nack_n = nack_seen;  lost_n = arb_lost;
        done_n = 1'b0;  rdv_n = 1'b0;  rdd_n = rd_data;  wr_take = 1'b0;
        left_dec = is_addr ? left : left - CNT_W'(1);
        case (st)
            ST_IDLE: if (cmd_start) begin
                head_n = '{addr: cmd_addr, rd: cmd_read};
                left_n = cmd_count;
                nack_n = 1'b0;
                lost_n = 1'b0;
                st_n   = ST_WAIT;
            end
            ST_WAIT: if (bus_free) begin
                st_n = ST_START;
                ph_n = 2'd0;
            end
            ST_START: if (tick) begin
                ph_n = ph + 2'd1;
                if (ph == PH_LAST) begin
                    st_n      = ST_BIT;
                    bitn_n    = 4'd0;
                    sh_n      = head_byte(head);
                    rx_n      = 1'b0;
                    is_addr_n = 1'b1;
                end
            end
            ST_BIT: if (tick) begin
                ph_n = ph + 2'd1;
                if (ph == PH_LAST) begin
                    if (bitn != ACK_SLOT) begin
                        bitn_n = bitn + 4'd1;
                        if (rx) begin
                            sh_n = {sh[6:0], sda_s};
                        end else if (sh[7] && !sda_s) begin
                            lost_n = 1'b1;
                            st_n   = ST_IDLE;
                        end else begin
                            sh_n = {sh[6:0], 1'b0};
                        end
                    end else begin
                        bitn_n = 4'd0;
                        if (rx) begin
                            rdv_n = 1'b1;
                            rdd_n = sh;
                        end
                        if (!rx && sda_s) begin
                            nack_n = 1'b1;
                            st_n   = ST_STOP;
                        end else begin
                            left_n = left_dec;
                            if (left_dec == '0) begin
                                st_n = ST_STOP;
                            end else begin
                                is_addr_n = 1'b0;
                                rx_n      = head.rd;
                                if (!head.rd) begin
                                    sh_n    = wr_data;
                                    wr_take = 1'b1;
                                end
                            end
                        end
                    end
                end
            end
            ST_STOP: if (tick) begin
                ph_n = ph + 2'd1;
                if (ph == PH_LAST) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Line drive for the phase being entered; data holds across phase 0
    always_comb begin
        drv_n = '{scl: 1'b0, sda: 1'b0};
        case (st_n)
            ST_START: drv_n.sda = (ph_n != 2'd0);
            ST_BIT: begin
                drv_n.scl = (ph_n < 2'd2);
                if (ph_n == 2'd0)          drv_n.sda = sda_oe;
                else if (bitn_n != ACK_SLOT) drv_n.sda = rx_n ? 1'b0 : !sh_n[7];
                else                       drv_n.sda = rx_n ? (left_n != CNT_W'(1)) : 1'b0;
            end
            ST_STOP: begin
                drv_n.scl = (ph_n < 2'd2);
                drv_n.sda = (ph_n == 2'd0) ? sda_oe : (ph_n != PH_LAST);
            end
            default: drv_n = '{scl: 1'b0, sda: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;  ph <= 2'd0;  bitn <= 4'd0;  sh <= 8'h00;
            rx <= 1'b0;  is_addr <= 1'b0;  left <= '0;  head <= '0;
            nack_seen <= 1'b0;  arb_lost <= 1'b0;  done <= 1'b0;
            rd_valid <= 1'b0;  rd_data <= 8'h00;
            scl_oe <= 1'b0;  sda_oe <= 1'b0;
        end else begin
            st <= st_n;  ph <= ph_n;  bitn <= bitn_n;  sh <= sh_n;
            rx <= rx_n;  is_addr <= is_addr_n;  left <= left_n;  head <= head_n;
            nack_seen <= nack_n;  arb_lost <= lost_n;  done <= done_n;
            rd_valid <= rdv_n;  rd_data <= rdd_n;
            scl_oe <= drv_n.scl;  sda_oe <= drv_n.sda;
        end
    end

    // R1: leaving the wait state needs the free indication
    a_r1_start_when_free: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START && $past(st) == ST_WAIT) |-> $past(bus_free));

    // R3: inside a byte the data enable moves only with the clock held low
    a_r3_data_moves_low_clock: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT && $past(st) == ST_BIT && sda_oe != $past(sda_oe))
            |-> (scl_oe && $past(scl_oe)));

    // R8: a loss leaves both lines released
    a_r8_release_on_loss: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> (!scl_oe && !sda_oe && !busy));

    // R11: done only follows a STOP
    a_r11_done_after_stop: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(st) == ST_STOP && !scl_oe && !sda_oe));
endmodule

// File: tb/tw_master_tb.sv
module tw_master_tb;
    localparam int DIV_W = 8;
    localparam int FREE_CYC = 32;
    localparam int MAX_BYTES = 8;
    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam logic [6:0] TGT = 7'h3A;
    localparam logic [7:0] REFUSE = 8'hEE;

    logic clk = 1'b0, rst = 1'b1;
    logic [DIV_W-1:0] div = 8'd3;

    logic d_start = 0, d_read = 0;  logic [6:0] d_addr = 0;  logic [CNT_W-1:0] d_cnt = 0;
    logic r_start = 0, r_read = 0;  logic [6:0] r_addr = 0;  logic [CNT_W-1:0] r_cnt = 0;
    logic [7:0] d_wr = 0, r_wr = 0;
    logic d_take, r_take, d_rdv, r_rdv, d_busy, r_busy, d_done, r_done;
    logic d_nack, r_nack, d_lost, r_lost, d_scl_oe, d_sda_oe, r_scl_oe, r_sda_oe;
    logic [7:0] d_rdd, r_rdd;
    logic sl_oe = 1'b0;

    wire bus_scl = ~(d_scl_oe | r_scl_oe);
    wire bus_sda = ~(d_sda_oe | r_sda_oe | sl_oe);

    int vectors = 0, miscompares = 0, cyc = 0;
    int start_cnt = 0, stop_cnt = 0, hi_min = 1000000, hi_max = 0, t_hi = 0;
    int d_done_cnt = 0, r_done_cnt = 0, d_takes = 0, r_takes = 0;
    bit d_take_seen = 0, r_take_seen = 0;
    logic [7:0] exp_q[$];
    string      exp_tag[$];
    logic [7:0] rd_exp[$];
    logic [7:0] d_wq[$], r_wq[$];
    bit         mack_q[$];
    logic [7:0] rd_mem[3] = '{8'hA5, 8'h3C, 8'h81};
    int  ridx = 0, scnt = 0, s_mode = 3;
    bit  s_act = 0, s_rd = 0, last_mack = 0;
    logic [7:0] s_sh = 0, s_tx = 0;

    tw_master #(.DIV_W(DIV_W), .FREE_CYC(FREE_CYC), .MAX_BYTES(MAX_BYTES)) u_dut (
        .clk(clk), .rst(rst), .div(div), .cmd_start(d_start), .cmd_addr(d_addr),
        .cmd_read(d_read), .cmd_count(d_cnt), .wr_data(d_wr), .wr_take(d_take),
        .rd_data(d_rdd), .rd_valid(d_rdv), .busy(d_busy), .done(d_done),
        .nack_seen(d_nack), .arb_lost(d_lost), .scl_i(bus_scl), .sda_i(bus_sda),
        .scl_oe(d_scl_oe), .sda_oe(d_sda_oe));

    tw_master #(.DIV_W(DIV_W), .FREE_CYC(FREE_CYC), .MAX_BYTES(MAX_BYTES)) u_rival (
        .clk(clk), .rst(rst), .div(div), .cmd_start(r_start), .cmd_addr(r_addr),
        .cmd_read(r_read), .cmd_count(r_cnt), .wr_data(r_wr), .wr_take(r_take),
        .rd_data(r_rdd), .rd_valid(r_rdv), .busy(r_busy), .done(r_done),
        .nack_seen(r_nack), .arb_lost(r_lost), .scl_i(bus_scl), .sda_i(bus_sda),
        .scl_oe(r_scl_oe), .sda_oe(r_sda_oe));

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        exp_tag.push_back(tag);
    endtask

    // Target model: wired-AND listener, acknowledges TGT, refuses REFUSE
    always @(negedge bus_sda) if (bus_scl === 1'b1) begin
        start_cnt++; s_act = 1; s_mode = 0; scnt = 0; sl_oe = 0;
    end
    always @(posedge bus_sda) if (bus_scl === 1'b1) begin
        stop_cnt++; s_act = 0; sl_oe = 0;
    end
    always @(posedge bus_scl) if (s_act) begin
        t_hi = cyc;
        scnt++;
        if (scnt <= 8) s_sh = {s_sh[6:0], bus_sda};
        else if (s_mode == 2) begin last_mack = !bus_sda; mack_q.push_back(!bus_sda); end
    end
    always @(negedge bus_scl) if (s_act) begin
        if (scnt > 0) begin
            if (cyc - t_hi < hi_min) hi_min = cyc - t_hi;
            if (cyc - t_hi > hi_max) hi_max = cyc - t_hi;
        end
        if (scnt == 8 && (s_mode == 0 || s_mode == 1)) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R2 unexpected byte actual=%0h expected=none", s_sh);
            end else begin
                if (s_sh !== exp_q[0]) begin
                    miscompares++;
                    $display("FAIL %s byte actual=%0h expected=%0h", exp_tag[0], s_sh, exp_q[0]);
                end
                void'(exp_q.pop_front());
                void'(exp_tag.pop_front());
            end
            if (s_mode == 0) begin
                if (s_sh[7:1] == TGT) begin sl_oe = 1; s_rd = s_sh[0]; end
                else s_mode = 3;
            end else sl_oe = (s_sh != REFUSE);
        end else if (scnt == 8 && s_mode == 2) begin
            sl_oe = 0;
        end else if (scnt == 9) begin
            sl_oe = 0; scnt = 0;
            if (s_mode == 0) s_mode = s_rd ? 2 : 1;
            else if (s_mode == 2 && !last_mack) s_mode = 3;
            if (s_mode == 2) begin
                s_tx = rd_mem[ridx % 3]; ridx++;
                sl_oe = !s_tx[7];
            end
        end else if (s_mode == 2 && scnt >= 1 && scnt <= 7) begin
            sl_oe = !s_tx[7 - scnt];
        end
    end

    // Host-side monitor: write data feeding, counters, read scoreboard
    always @(negedge clk) begin
        if (d_take_seen) void'(d_wq.pop_front());
        if (r_take_seen) void'(r_wq.pop_front());
        d_take_seen = d_take;  r_take_seen = r_take;
        if (d_take) d_takes++;
        if (r_take) r_takes++;
        d_wr = (d_wq.size() > 0) ? d_wq[0] : 8'h00;
        r_wr = (r_wq.size() > 0) ? r_wq[0] : 8'h00;
        if (d_done) d_done_cnt++;
        if (r_done) r_done_cnt++;
        if (d_rdv) begin
            vectors++;
            if (rd_exp.size() == 0) begin
                miscompares++;
                $display("FAIL R7 extra read actual=%0h expected=none", d_rdd);
            end else begin
                if (d_rdd !== rd_exp[0]) begin
                    miscompares++;
                    $display("FAIL R7 read byte actual=%0h expected=%0h", d_rdd, rd_exp[0]);
                end
                void'(rd_exp.pop_front());
            end
        end
    end

    task automatic clr();
        start_cnt = 0; stop_cnt = 0; hi_min = 1000000; hi_max = 0;
        d_takes = 0; r_takes = 0; mack_q.delete();
    endtask

    task automatic dut_cmd(input logic [6:0] a, input logic rd, input int n);
        d_addr = a; d_read = rd; d_cnt = CNT_W'(n); d_start = 1;
        @(negedge clk); d_start = 0;
    endtask

    task automatic wait_dut_done();
        int d0 = d_done_cnt;
        while (d_done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int wait_c, t_rdone, t_dstart;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk("R11 scl_oe after reset", d_scl_oe, 0);
        chk("R11 sda_oe after reset", d_sda_oe, 0);
        chk("R11 busy after reset", d_busy, 0);
        chk("R11 flags after reset", {d_lost, d_nack}, 0);
        clr();

        // R1: first START waits out FREE_CYC after reset
        expect_byte({TGT, 1'b0}, "R2 addr");
        expect_byte(8'h5A, "R4 wdata");
        d_wq.push_back(8'h5A);
        dut_cmd(TGT, 0, 1);
        wait_c = 1;
        while (!d_sda_oe) begin @(negedge clk); wait_c++; end
        chk("R1 start not before bus free", (wait_c >= FREE_CYC - 3), 1);
        chk("R1 start soon after bus free", (wait_c <= FREE_CYC + 2 * (int'(div) + 1) + 4), 1);
        wait_dut_done();
        chk("R4 single write taken", d_takes, 1);
        chk("R11 done seen", d_done_cnt, 1);
        chk("R3 one start one stop", {start_cnt[7:0], stop_cnt[7:0]}, 16'h0101);
        chk("R10 scl high min div3", hi_min, 8);
        chk("R10 scl high max div3", hi_max, 8);

        // R2/R4: multi-byte write
        clr();
        expect_byte({TGT, 1'b0}, "R2 addr");
        foreach (d_wq[i]) ;
        d_wq.push_back(8'hC3); d_wq.push_back(8'h00); d_wq.push_back(8'h7E);
        expect_byte(8'hC3, "R4 wdata0"); expect_byte(8'h00, "R4 wdata1"); expect_byte(8'h7E, "R4 wdata2");
        dut_cmd(TGT, 0, 3);
        wait_dut_done();
        chk("R4 three writes taken", d_takes, 3);
        chk("R2 all bytes seen", exp_q.size(), 0);
        chk("R4 no nack", d_nack, 0);
        chk("R3 start/stop pair", {start_cnt[7:0], stop_cnt[7:0]}, 16'h0101);

        // R7: read three bytes
        clr(); ridx = 0;
        expect_byte({TGT, 1'b1}, "R2 read addr");
        rd_exp.push_back(8'hA5); rd_exp.push_back(8'h3C); rd_exp.push_back(8'h81);
        dut_cmd(TGT, 1, 3);
        wait_dut_done();
        chk("R7 reads delivered", rd_exp.size(), 0);
        chk("R7 master ack count", mack_q.size(), 3);
        if (mack_q.size() == 3)
            chk("R7 ack ack nack", {mack_q[0], mack_q[1], mack_q[2]}, 3'b110);
        chk("R7 no write takes", d_takes, 0);

        // R5: address not acknowledged
        clr();
        expect_byte({7'h11, 1'b0}, "R5 addr");
        d_wq.push_back(8'h99); d_wq.push_back(8'h98);
        dut_cmd(7'h11, 0, 2);
        wait_dut_done();
        chk("R5 nack flagged", d_nack, 1);
        chk("R5 no data taken", d_takes, 0);
        chk("R5 stop issued", stop_cnt, 1);
        d_wq.delete();

        // R6: refused data byte; R9 new command clears nack
        clr();
        expect_byte({TGT, 1'b0}, "R6 addr");
        expect_byte(8'h11, "R6 wdata0"); expect_byte(REFUSE, "R6 refused");
        d_wq.push_back(8'h11); d_wq.push_back(REFUSE); d_wq.push_back(8'h22);
        dut_cmd(TGT, 0, 3);
        chk("R9 nack cleared by command", d_nack, 0);
        wait_dut_done();
        chk("R6 nack flagged", d_nack, 1);
        chk("R6 taken until refusal", d_takes, 2);
        chk("R6 bytes seen", exp_q.size(), 0);
        d_wq.delete();

        // R8: simultaneous start, rival loses on the last address bit
        clr();
        expect_byte({TGT, 1'b0}, "R8 winner addr");
        expect_byte(8'h96, "R8 winner data0"); expect_byte(8'h4B, "R8 winner data1");
        d_wq.push_back(8'h96); d_wq.push_back(8'h4B);
        r_wq.push_back(8'hFF);
        d_addr = TGT; d_read = 0; d_cnt = 2;
        r_addr = 7'h3B; r_read = 0; r_cnt = 1;
        d_start = 1; r_start = 1;
        @(negedge clk); d_start = 0; r_start = 0;
        wait_dut_done();
        chk("R8 rival lost", r_lost, 1);
        chk("R8 rival idle", r_busy, 0);
        chk("R8 winner not lost", d_lost, 0);
        chk("R8 winner bytes intact", exp_q.size(), 0);
        chk("R8 loser sent no stop", {start_cnt[7:0], stop_cnt[7:0]}, 16'h0101);
        chk("R8 loser took no data", r_takes, 0);
        chk("R9 loss flag sticky", r_lost, 1);
        r_wq.delete();

        // R8/R9: this master loses on the first bit, then retries
        clr();
        expect_byte({TGT, 1'b0}, "R8 rival addr");
        expect_byte(8'hE7, "R8 rival data0"); expect_byte(8'h18, "R8 rival data1");
        expect_byte({TGT, 1'b0}, "R9 retry addr"); expect_byte(8'h01, "R9 retry data");
        r_wq.push_back(8'hE7); r_wq.push_back(8'h18);
        d_wq.push_back(8'h01);
        d_addr = 7'h50; d_read = 0; d_cnt = 1;
        r_addr = TGT; r_read = 0; r_cnt = 2;
        d_start = 1; r_start = 1;
        @(negedge clk); d_start = 0; r_start = 0;
        while (!d_lost) @(negedge clk);
        chk("R8 lines released on loss", {d_scl_oe, d_sda_oe}, 2'b00);
        chk("R8 busy dropped on loss", d_busy, 0);
        dut_cmd(TGT, 0, 1);
        chk("R9 loss flag cleared by command", d_lost, 0);
        t_rdone = -1; t_dstart = -1;
        while (t_dstart < 0) begin
            if (r_done && t_rdone < 0) t_rdone = cyc;
            if (d_sda_oe) t_dstart = cyc;
            @(negedge clk);
        end
        chk("R9 retry waits for free bus", (t_rdone >= 0 && t_dstart > t_rdone), 1);
        wait_dut_done();
        chk("R9 retry completes", d_takes, 1);
        chk("R8 rival kept the bus", r_lost, 0);
        chk("R8 all bytes in order", exp_q.size(), 0);
        chk("R3 two transfers framed", {start_cnt[7:0], stop_cnt[7:0]}, 16'h0202);

        // R10: longer quarter
        repeat (20) @(negedge clk);
        div = 8'd5;
        clr();
        expect_byte({TGT, 1'b0}, "R10 addr"); expect_byte(8'h3D, "R10 data");
        d_wq.push_back(8'h3D);
        dut_cmd(TGT, 0, 1);
        wait_dut_done();
        chk("R10 scl high min div5", hi_min, 12);
        chk("R10 scl high max div5", hi_max, 12);
        chk("R10 bytes seen", exp_q.size(), 0);

        finish_run();
    end
endmodule